// File: doc/BRIEF.md
# Queued Interrupt Status Controller

This block collects interrupt sources and presents them to a host as one status register and one interrupt line. Sources come in two kinds. Each channel raises a one-cycle done pulse when it finishes a unit of work. Each general source holds a level condition for as long as its cause persists. Every status bit has its own enable bit. The host acknowledges a bit by writing a one to that bit position in a clear register.

Done pulses from a channel can arrive faster than the host services them, so no event may be lost. While a channel's done bit is pending, further done pulses are counted in a small per-channel queue. Each host acknowledge retires one event. If events remain after the acknowledge, the done bit goes low for exactly one cycle and then comes back. If the queue is already full when another event arrives, a per-channel overflow bit is raised.

Top module: `qis_ctrl`

## Requirements
- R1: A status bit becomes set only after its source fires while the matching bit of the enable register is 1. With the enable bit at 0, the source leaves the status register and `irq` unchanged.
- R2: Writing 1 to bit k of the clear register while status bit k is set clears that bit on the next clock, for overflow and level bits whose cause is gone.
- R3: A channel done pulse that arrives while that channel's done bit is set is queued, up to QMAX queued pulses per channel.
- R4: A clear of a done bit with an empty queue leaves the done bit at 0 from the next clock. A clear written while the done bit is 0 has no effect.
- R5: A clear of a done bit with a non-empty queue removes one queued pulse. The done bit then reads 0 for exactly one cycle and 1 on the cycle after, and `irq` stays at 1 through the gap.
- R6: A done pulse that arrives while the queue holds QMAX pulses leaves the count at QMAX and sets that channel's overflow bit, if its enable bit is 1.
- R7: If a level condition is still present (and enabled) when its status bit is cleared, the bit reads 0 for one cycle and is set again on the following cycle, and `irq` stays at 1 throughout.
- R8: `irq` is the OR of all set status bits and all bits about to reassert. After reset, every register, the status and `irq` are 0.
- R9: If a done pulse and a clear of that done bit land in the same cycle while the bit is set, the done bit stays at 1 and the queue count is unchanged.
- R10: An overflow bit stays set until it is cleared through the clear register, and stays set across done-bit clears.
- R11: Register map by `reg_addr`: 0 is the enable register (read/write), 1 is status (read-only), 2 is clear (write-one, reads 0), and 3 reads 0. Status layout: bits [NUM_CH-1:0] are the channel done bits, the next NUM_CH bits are the overflow bits in channel order, and the top NUM_MISC bits are the level sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| done_evt | input | NUM_CH | One-cycle done pulse per channel |
| cond | input | NUM_MISC | Level interrupt conditions |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 2*NUM_CH+NUM_MISC | Write data |
| reg_rdata | output | 2*NUM_CH+NUM_MISC | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt line to the host |

## Verification
The bench builds the block with two channels, two level sources and a queue limit of 3. With a queue that shallow, every fill level from empty to past overflow can be swept on each channel. Each sweep drains the queue one clear at a time, and the expected done, overflow and `irq` values follow from the number of pulses sent. The two level sources are enough to exercise enable gating, the reassert gap and the register map. They also cover the case where a pulse and a clear land in the same cycle.

// File: rtl/qis_pkg.sv
package qis_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 2'd0,
    REG_STATUS = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/qis_rst_sync.sv
module qis_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/qis_done_queue.sv
// Per-channel done bit with a saturating queue of pending events.
module qis_done_queue #(
  parameter int QMAX = 15,
  parameter int CW   = $clog2(QMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,     // enable-gated done pulse
  input  logic          clr_i,     // host clear of the done bit
  output logic          done_o,
  output logic          rearm_o,   // done will reassert next cycle
  output logic [CW-1:0] count_o,
  output logic          ovf_evt_o  // pulse arrived with queue full
);
  localparam logic [CW-1:0] CMAX = CW'(QMAX);

  logic          done_q, done_n;
  logic          rearm_q, rearm_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          bump;
  logic          adv;

  assign adv = evt_i | clr_i | rearm_q;

  always_comb begin
    done_n    = done_q;
    rearm_n   = 1'b0;
    cnt_n     = cnt_q;
    bump      = 1'b0;
    ovf_evt_o = 1'b0;
    if (rearm_q) begin
      done_n = 1'b1;
      bump   = evt_i;
    end else if (!done_q) begin
      done_n = evt_i;
    end else if (evt_i && !clr_i) begin
      bump = 1'b1;
    end else if (clr_i && !evt_i) begin
      done_n = 1'b0;
      if (cnt_q != '0) begin
        cnt_n   = cnt_q - 1'b1;
        rearm_n = 1'b1;
      end
    end
    if (bump) begin
      if (cnt_q == CMAX) ovf_evt_o = 1'b1;
      else               cnt_n     = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rearm_q <= 1'b0;
      cnt_q   <= '0;
    end else if (adv) begin
      done_q  <= done_n;
      rearm_q <= rearm_n;
      cnt_q   <= cnt_n;
    end
  end

  assign done_o  = done_q;
  assign rearm_o = rearm_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/qis_status_bit.sv
// Sticky status bit; clearing while the cause persists drops it one cycle.
module qis_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic stat_o,
  output logic rearm_o
);
  logic stat_q, stat_n;
  logic rearm_q, rearm_n;
  logic adv;

  assign adv = set_i | clr_i | rearm_q;

  always_comb begin
    rearm_n = clr_i & stat_q & set_i;
    if (clr_i && stat_q) stat_n = 1'b0;
    else                 stat_n = stat_q | set_i | rearm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      rearm_q <= 1'b0;
    end else if (adv) begin
      stat_q  <= stat_n;
      rearm_q <= rearm_n;
    end
  end

  assign stat_o  = stat_q;
  assign rearm_o = rearm_q;
endmodule

// File: rtl/qis_regfile.sv
module qis_regfile
  import qis_pkg::*;
#(
  parameter int NSTAT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSTAT-1:0]  wdata_i,
  input  logic [NSTAT-1:0]  status_i,
  output logic [NSTAT-1:0]  enable_o,
  output logic [NSTAT-1:0]  clear_o,
  output logic [NSTAT-1:0]  rdata_o
);
  logic [NSTAT-1:0] en_q;
  logic             en_we;

  assign en_we   = wr_i && (addr_i == REG_ENABLE);
  assign clear_o = (wr_i && (addr_i == REG_CLEAR)) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= wdata_i;
  end

  always_comb begin
    case (addr_i)
      REG_ENABLE: rdata_o = en_q;
      REG_STATUS: rdata_o = status_i;
      default:    rdata_o = '0;
    endcase
  end

  assign enable_o = en_q;
endmodule

// File: rtl/qis_ctrl.sv
module qis_ctrl
  import qis_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_MISC = 4,
  parameter int QMAX     = 15,
  localparam int CW      = $clog2(QMAX + 1),
  localparam int NSTAT   = 2 * NUM_CH + NUM_MISC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   done_evt,
  input  logic [NUM_MISC-1:0] cond,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NSTAT-1:0]    reg_wdata,
  output logic [NSTAT-1:0]    reg_rdata,
  output logic                irq
);
  localparam int OVF_LO  = NUM_CH;
  localparam int MISC_LO = 2 * NUM_CH;

  logic                 rst_sync_n;
  logic [NSTAT-1:0]     status;
  logic [NSTAT-1:0]     rearm;
  logic [NSTAT-1:0]     enable;
  logic [NSTAT-1:0]     clear;
  logic [NUM_CH-1:0]    ovf_evt;
  logic [NUM_CH*CW-1:0] count_flat;

  qis_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  qis_regfile #(.NSTAT(NSTAT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .status_i (status),
    .enable_o (enable),
    .clear_o  (clear),
    .rdata_o  (reg_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qis_done_queue #(.QMAX(QMAX), .CW(CW)) u_q (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .evt_i     (done_evt[c] & enable[c]),
      .clr_i     (clear[c]),
      .done_o    (status[c]),
      .rearm_o   (rearm[c]),
      .count_o   (count_flat[c*CW +: CW]),
      .ovf_evt_o (ovf_evt[c])
    );

    qis_status_bit u_ovf (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_i   (ovf_evt[c] & enable[OVF_LO+c]),
      .clr_i   (clear[OVF_LO+c]),
      .stat_o  (status[OVF_LO+c]),
      .rearm_o (rearm[OVF_LO+c])
    );
  end

  for (genvar m = 0; m < NUM_MISC; m++) begin : g_misc
    qis_status_bit u_lvl (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_i   (cond[m] & enable[MISC_LO+m]),
      .clr_i   (clear[MISC_LO+m]),
      .stat_o  (status[MISC_LO+m]),
      .rearm_o (rearm[MISC_LO+m])
    );
  end

  assign irq = (|status) | (|rearm);
endmodule

// File: rtl/qis_ctrl_chk.sv
module qis_ctrl_chk
  import qis_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_MISC = 4,
  parameter int QMAX     = 15,
  localparam int CW      = $clog2(QMAX + 1),
  localparam int NSTAT   = 2 * NUM_CH + NUM_MISC
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    done_evt,
  input logic [NUM_MISC-1:0]  cond,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [NSTAT-1:0]     reg_wdata,
  input logic [NSTAT-1:0]     status,
  input logic [NSTAT-1:0]     enable,
  input logic [NUM_CH*CW-1:0] count_flat,
  input logic                 irq
);
  localparam int OVF_LO  = NUM_CH;
  localparam int MISC_LO = 2 * NUM_CH;
  localparam logic [CW-1:0] CMAX = CW'(QMAX);

  logic [NSTAT-1:0] clr_v;
  assign clr_v = (reg_wr && reg_addr == REG_CLEAR) ? reg_wdata : '0;

  AST_IRQ_COVERS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|status) |-> irq); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic          evt_g;
    logic [CW-1:0] cnt;
    assign evt_g = done_evt[c] & enable[c];
    assign cnt   = count_flat[c*CW +: CW];

    AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      status[c] && clr_v[c] && !evt_g && cnt == '0 |=> !status[c]); // R4
    AST_QUEUE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      status[c] && clr_v[c] && !evt_g && cnt != '0 |=> !status[c] && irq ##1 status[c]); // R5
    AST_COINCIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      status[c] && clr_v[c] && evt_g |=> status[c] && $stable(cnt)); // R9
    AST_QUEUE_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      status[c] && evt_g && !clr_v[c] && cnt == CMAX && enable[OVF_LO+c]
      |=> cnt == CMAX && status[OVF_LO+c]); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      status[OVF_LO+c] && !clr_v[OVF_LO+c] |=> status[OVF_LO+c]); // R10
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      status[OVF_LO+c] && clr_v[OVF_LO+c] |=> !status[OVF_LO+c]); // R2
  end

  for (genvar m = 0; m < NUM_MISC; m++) begin : g_misc
    localparam int B = MISC_LO + m;
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      status[B] && clr_v[B] && cond[m] && enable[B] |=> !status[B] && irq ##1 status[B]); // R7
    AST_LEVEL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[B]) |-> $past(enable[B]) || $past(enable[B], 2)); // R1
  end
endmodule

bind qis_ctrl qis_ctrl_chk #(
  .NUM_CH   (NUM_CH),
  .NUM_MISC (NUM_MISC),
  .QMAX     (QMAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .done_evt   (done_evt),
  .cond       (cond),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .status     (status),
  .enable     (enable),
  .count_flat (count_flat),
  .irq        (irq)
);

// File: tb/sim_qis_ctrl.sv
`timescale 1ns/100ps
module sim_qis_ctrl;
  localparam int NCH   = 2;
  localparam int NMISC = 2;
  localparam int QM    = 3;
  localparam int NS    = 2 * NCH + NMISC;

  logic            clk;
  logic            rst_n;
  logic [NCH-1:0]  done_evt;
  logic [NMISC-1:0] cond;
  logic            reg_wr;
  logic [1:0]      reg_addr;
  logic [NS-1:0]   reg_wdata;
  logic [NS-1:0]   reg_rdata;
  logic            irq;

  int n_chk;
  int n_fail;

  qis_ctrl #(.NUM_CH(NCH), .NUM_MISC(NMISC), .QMAX(QM)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_evt  (done_evt),
    .cond      (cond),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1; reg_wdata = '0;
    #0.5;
  endtask

  task automatic pulse(input int c);
    @(negedge clk);
    done_evt[c] = 1'b1;
    @(negedge clk);
    done_evt = '0;
    #0.5;
  endtask

  task automatic rd(input logic [1:0] a, output logic [NS-1:0] v);
    reg_addr = a;
    #0.2;
    v = reg_rdata;
    reg_addr = 2'd1;
    #0.2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; done_evt = '0; cond = '0;
    reg_wr = 1'b0; reg_addr = 2'd1; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
  endtask

  initial begin
    logic [NS-1:0] v;
    n_chk = 0; n_fail = 0;

    // Reset state
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R8", "reset register", 32'(v), 32'd0);
    end
    chk("R8", "reset irq", 32'(irq), 32'd0);

    // Enable gating and register map
    pulse(0); pulse(1);
    cond = 2'b11;
    step(); step();
    chk("R1", "status with enables off", 32'(reg_rdata), 32'd0);
    chk("R1", "irq with enables off", 32'(irq), 32'd0);
    wr(2'd0, 6'h10);
    step();
    chk("R1", "only enabled level bit set", 32'(reg_rdata), 32'h10);
    rd(2'd0, v); chk("R11", "enable readback", 32'(v), 32'h10);
    rd(2'd2, v); chk("R11", "clear reads zero", 32'(v), 32'd0);
    rd(2'd3, v); chk("R11", "spare reads zero", 32'(v), 32'd0);

    // Level reassert gap
    wr(2'd2, 6'h10);
    chk("R7", "level bit in gap", 32'(reg_rdata[4]), 32'd0);
    chk("R7", "irq held in gap", 32'(irq), 32'd1);
    step();
    chk("R7", "level bit back", 32'(reg_rdata[4]), 32'd1);
    cond = 2'b00;
    step();
    wr(2'd2, 6'h10);
    chk("R2", "level bit cleared", 32'(reg_rdata[4]), 32'd0);
    chk("R2", "irq low after clear", 32'(irq), 32'd0);
    step();
    chk("R2", "level bit stays clear", 32'(reg_rdata[4]), 32'd0);

    // Queue sweep per channel and fill level
    for (int c = 0; c < NCH; c++) begin
      for (int n = 0; n <= QM + 2; n++) begin
        int  nq;
        logic eovf;
        do_reset();
        wr(2'd0, 6'h3F);
        for (int i = 0; i < n; i++) pulse(c);
        step();
        eovf = (n > QM + 1);
        nq   = eovf ? QM + 1 : n;
        chk("R3", "done after pulses", 32'(reg_rdata[c]), 32'(n > 0));
        chk("R6", "overflow after pulses", 32'(reg_rdata[NCH+c]), 32'(eovf));
        chk("R8", "irq after pulses", 32'(irq), 32'(n > 0));
        for (int k = 1; k <= nq; k++) begin
          wr(2'd2, NS'(1) << c);
          if (k < nq) begin
            chk("R5", "done in gap", 32'(reg_rdata[c]), 32'd0);
            chk("R5", "irq in gap", 32'(irq), 32'd1);
            step();
            chk("R5", "done reasserted", 32'(reg_rdata[c]), 32'd1);
          end else begin
            chk("R4", "done after last clear", 32'(reg_rdata[c]), 32'd0);
            chk("R4", "irq after last clear", 32'(irq), 32'(eovf));
          end
        end
        wr(2'd2, NS'(1) << c);
        step();
        chk("R4", "extra clear keeps done low", 32'(reg_rdata[c]), 32'd0);
        chk("R10", "overflow sticky", 32'(reg_rdata[NCH+c]), 32'(eovf));
        wr(2'd2, NS'(1) << (NCH + c));
        chk("R2", "overflow cleared", 32'(reg_rdata[NCH+c]), 32'd0);
        chk("R2", "irq idle", 32'(irq), 32'd0);
      end
    end

    // Coincident pulse and clear
    do_reset();
    wr(2'd0, 6'h3F);
    pulse(1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 6'h02; done_evt[1] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1; reg_wdata = '0; done_evt = '0;
    #0.5;
    chk("R9", "done held on coincidence", 32'(reg_rdata[1]), 32'd1);
    wr(2'd2, 6'h02);
    chk("R9", "queue unchanged so single clear empties", 32'(reg_rdata[1]), 32'd0);
    chk("R9", "irq low", 32'(irq), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule